// File: doc/BRIEF.md
# Split-Transaction Bus Arbiter with Address Pipelining

This block controls a shared bus that is divided into three channels: one that carries requests and addresses, one that carries read data and one that carries write data. Masters compete only for the request channel. A round-robin arbiter picks one requester. That master keeps the request channel until the addressed slave accepts the request. The channel is then freed at once, so the next request can be presented while earlier transfers are still moving data.

Each accepted transaction is placed in the in-order queue of its direction. The head of each queue owns its data channel. The read channel is handed to the oldest accepted read, and the write channel to the oldest accepted write. A later read or write that was accepted early waits in its queue until the earlier burst has moved its last beat. The two data channels are independent, so a read burst and a write burst can run in the same cycles.

Top module: `split_bus_arb`

## Requirements
- R1: A synchronous reset, active high, drops every grant, empties both queues and points the round-robin search at master 0. After reset, if all masters request at once, master 0 is granted first.
- R2: No more than one grant bit is ever high. When the request channel is idle and an eligible master requests, its grant bit rises one clock after the request is sampled. A single requesting master is granted with no other condition.
- R3: Priority rotates. After master k is granted, the search for the next grant starts at master k+1, wrapping from the highest index to 0.
- R4: A grant stays high until the slave raises `addr_ack`. The grant is low in the cycle after the acknowledge, and the next grant can appear one cycle after that.
- R5: When a request is acknowledged, the granted master's index and burst length are stored in the read queue if its `req_write` bit is 0, or in the write queue if that bit is 1. The owner output of that channel shows the oldest stored transaction one cycle after the acknowledge.
- R6: `req_len` holds the number of beats minus one, in 4 bits per master, so a burst is 1 to 16 beats. Master m's field is bits [4m+3:4m]. A channel's owner moves on in the cycle after the beat that completes the burst.
- R7: The read channel and the write channel track ownership independently. A read burst and a write burst can be owned and advanced in the same cycles.
- R8: Each queue holds at most 2 transactions. While a queue is full, masters requesting that direction are skipped by the arbiter. Requests of the other direction can still be granted.
- R9: A data beat strobe on a channel that has no owner has no effect. It is not counted toward any later burst.
- R10: A read (or write) accepted while an earlier one of the same direction is still transferring does not take ownership until the earlier burst has finished. Ownership follows acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_MASTERS | Per-master request for the request channel |
| req_write | input | N_MASTERS | Per-master direction: 1 = write, 0 = read |
| req_len | input | N_MASTERS*LEN_W | Per-master burst length minus one |
| addr_ack | input | 1 | Slave accepts the request currently on the channel |
| rd_beat | input | 1 | One read-data beat transferred |
| wr_beat | input | 1 | One write-data beat transferred |
| gnt | output | N_MASTERS | One-hot grant of the request channel |
| rd_owner_valid | output | 1 | Read channel has an owner |
| rd_owner | output | IDX_W | Master that owns the read channel |
| wr_owner_valid | output | 1 | Write channel has an owner |
| wr_owner | output | IDX_W | Master that owns the write channel |

## Verification
A grant is registered, so it is visible one clock after the request is presented. The grant is low one clock after the acknowledge, and a queued owner is visible one clock after that same acknowledge. An owner advances one clock after the beat that completes its burst. The bench drives inputs and samples outputs on the falling edge, and it compares each result exactly one rising edge after the stimulus that causes it. For a full queue, it checks that the grant stays low in the cycle when the pop is registered, and that the grant appears one cycle later.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] eligible,
    input  logic [IDX_W-1:0]     start,
    output logic                 pick_valid,
    output logic [IDX_W-1:0]     pick_idx
);
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            int j;
            j = int'(start) + i;
            if (j >= N_MASTERS) j = j - N_MASTERS;
            if (eligible[j]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/sba_txn_queue.sv
module sba_txn_queue #(
    parameter int ID_W  = 2,
    parameter int LEN_W = 4,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic [LEN_W-1:0] push_len,
    input  logic             beat,
    output logic             head_valid,
    output logic [ID_W-1:0]  head_id,
    output logic             full
);
    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0]  ids;
        logic [DEPTH-1:0][LEN_W-1:0] lens;
        logic [PTR_W-1:0]            rd_ptr;
        logic [PTR_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            count;
        logic [LEN_W-1:0]            beat_cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     pop;

    assign head_valid = (st_q.count != '0);
    assign head_id    = st_q.ids[st_q.rd_ptr];
    assign full       = (st_q.count == CNT_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        pop  = beat && head_valid && (st_q.beat_cnt == st_q.lens[st_q.rd_ptr]);
        if (beat && head_valid)
            st_d.beat_cnt = pop ? '0 : st_q.beat_cnt + 1'b1;
        if (pop)
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        if (push) begin
            st_d.ids[st_q.wr_ptr]  = push_id;
            st_d.lens[st_q.wr_ptr] = push_len;
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full)
        else $error("push into a full queue");

    p_owner_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !pop) |=> (head_valid && head_id == $past(head_id)))
        else $error("owner changed before its burst ended");

    p_beat_bound_r6: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> (st_q.beat_cnt <= st_q.lens[st_q.rd_ptr]))
        else $error("beat count passed burst length");
endmodule

// File: rtl/split_bus_arb.sv
module split_bus_arb #(
    parameter int N_MASTERS = 4,
    parameter int LEN_W     = 4,
    parameter int Q_DEPTH   = 2,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_MASTERS-1:0]       req_valid,
    input  logic [N_MASTERS-1:0]       req_write,
    input  logic [N_MASTERS*LEN_W-1:0] req_len,
    input  logic                       addr_ack,
    input  logic                       rd_beat,
    input  logic                       wr_beat,
    output logic [N_MASTERS-1:0]       gnt,
    output logic                       rd_owner_valid,
    output logic [IDX_W-1:0]           rd_owner,
    output logic                       wr_owner_valid,
    output logic [IDX_W-1:0]           wr_owner
);
    import sba_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t          st_d, st_q;
    logic [N_MASTERS-1:0] eligible;
    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;
    logic                 rd_full, wr_full;
    logic                 rd_push, wr_push;
    dir_e                 cur_dir;
    logic [LEN_W-1:0]     cur_len;

    always_comb begin
        for (int m = 0; m < N_MASTERS; m++)
            eligible[m] = req_valid[m] && !(req_write[m] ? wr_full : rd_full);
    end

    sba_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .eligible   (eligible),
        .start      (st_q.ptr),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    assign cur_dir = dir_e'(req_write[st_q.idx]);
    assign cur_len = req_len[st_q.idx*LEN_W +: LEN_W];
    assign rd_push = st_q.busy && addr_ack && (cur_dir == DIR_READ);
    assign wr_push = st_q.busy && addr_ack && (cur_dir == DIR_WRITE);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (addr_ack) st_d.busy = 1'b0;
        end else if (pick_valid) begin
            st_d.busy = 1'b1;
            st_d.idx  = pick_idx;
            st_d.ptr  = (pick_idx == IDX_W'(N_MASTERS - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        gnt = '0;
        if (st_q.busy) gnt[st_q.idx] = 1'b1;
    end

    sba_txn_queue #(.ID_W(IDX_W), .LEN_W(LEN_W), .DEPTH(Q_DEPTH)) u_rd_q (
        .clk (clk), .rst (rst),
        .push (rd_push), .push_id (st_q.idx), .push_len (cur_len),
        .beat (rd_beat),
        .head_valid (rd_owner_valid), .head_id (rd_owner), .full (rd_full)
    );

    sba_txn_queue #(.ID_W(IDX_W), .LEN_W(LEN_W), .DEPTH(Q_DEPTH)) u_wr_q (
        .clk (clk), .rst (rst),
        .push (wr_push), .push_id (st_q.idx), .push_len (cur_len),
        .beat (wr_beat),
        .head_valid (wr_owner_valid), .head_id (wr_owner), .full (wr_full)
    );

    p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt))
        else $error("more than one grant");

    p_hold_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && !addr_ack) |=> (gnt == $past(gnt)))
        else $error("grant moved before acknowledge");

    p_release_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        ((|gnt) && addr_ack) |=> (gnt == '0))
        else $error("grant kept after acknowledge");

    p_pick_eligible_r8: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> (req_valid[pick_idx] && !(req_write[pick_idx] ? wr_full : rd_full)))
        else $error("picked a blocked master");
endmodule

// File: tb/split_bus_arb_tb.sv
module split_bus_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NM-1:0] req_valid, req_write;
    logic [NM*LW-1:0] req_len;
    logic          addr_ack, rd_beat, wr_beat;
    logic [NM-1:0] gnt;
    logic          rd_owner_valid, wr_owner_valid;
    logic [1:0]    rd_owner, wr_owner;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_bus_arb #(.N_MASTERS(NM), .LEN_W(LW)) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write), .req_len (req_len),
        .addr_ack (addr_ack), .rd_beat (rd_beat), .wr_beat (wr_beat),
        .gnt (gnt),
        .rd_owner_valid (rd_owner_valid), .rd_owner (rd_owner),
        .wr_owner_valid (wr_owner_valid), .wr_owner (wr_owner)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = '0; req_write = '0; req_len = '0;
        addr_ack = 1'b0; rd_beat = 1'b0; wr_beat = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic set_req(input int m, input bit w, input int len);
        req_valid[m] = 1'b1;
        req_write[m] = w;
        req_len[m*LW +: LW] = LW'(len);
    endtask

    // request alone, get granted, get acknowledged
    task automatic accept_one(input int m, input bit w, input int len, input string tag);
        set_req(m, w, len);
        tick();
        chk_eq({tag, " grant"}, int'(gnt), 1 << m);
        addr_ack = 1'b1;
        req_valid[m] = 1'b0;
        tick();
        addr_ack = 1'b0;
        chk_eq({tag, " released"}, int'(gnt), 0);
    endtask

    task automatic pulse_rd();
        rd_beat = 1'b1; tick(); rd_beat = 1'b0;
    endtask

    task automatic pulse_wr();
        wr_beat = 1'b1; tick(); wr_beat = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R1 gnt after reset", int'(gnt), 0);
        chk_eq("R1 rd owner after reset", int'(rd_owner_valid), 0);
        chk_eq("R1 wr owner after reset", int'(wr_owner_valid), 0);
    endtask

    task automatic t_single();
        do_reset();
        accept_one(2, 1'b0, 0, "R2 single master");
        chk_eq("R5 read owner valid", int'(rd_owner_valid), 1);
        chk_eq("R5 read owner id", int'(rd_owner), 2);
        chk_eq("R5 write channel untouched", int'(wr_owner_valid), 0);
        pulse_rd();
        chk_eq("R6 one-beat read done", int'(rd_owner_valid), 0);
    endtask

    task automatic t_round_robin();
        int exp_order[5] = '{0, 1, 2, 3, 0};
        do_reset();
        wr_beat = 1'b1;
        for (int m = 0; m < NM; m++) set_req(m, 1'b1, 0);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk_eq("R3 rotation grant", int'(gnt), 1 << exp_order[k]);
            addr_ack = 1'b1;
            tick();
            addr_ack = 1'b0;
            chk_eq("R4 gap after ack", int'(gnt), 0);
        end
        req_valid = '0;
        tick(); tick();
        wr_beat = 1'b0;
        chk_eq("R1 r3 drained", int'(wr_owner_valid), 0);
    endtask

    task automatic t_hold();
        do_reset();
        set_req(1, 1'b0, 0);
        tick();
        chk_eq("R2 grant one cycle later", int'(gnt), 2);
        set_req(0, 1'b1, 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk_eq("R4 grant held without ack", int'(gnt), 2);
        end
        addr_ack = 1'b1; req_valid[1] = 1'b0;
        tick();
        addr_ack = 1'b0;
        chk_eq("R4 grant dropped after ack", int'(gnt), 0);
        tick();
        chk_eq("R4 next grant", int'(gnt), 1);
        addr_ack = 1'b1; req_valid[0] = 1'b0;
        tick();
        addr_ack = 1'b0;
    endtask

    task automatic t_concurrent();
        do_reset();
        accept_one(0, 1'b0, 3, "R7 read accept");
        accept_one(1, 1'b1, 1, "R7 write accept");
        chk_eq("R7 read owned", int'(rd_owner), 0);
        chk_eq("R7 write owned", int'(wr_owner), 1);
        chk_eq("R7 both valid", int'(rd_owner_valid && wr_owner_valid), 1);
        rd_beat = 1'b1; wr_beat = 1'b1;
        tick(); tick();
        wr_beat = 1'b0;
        chk_eq("R7 write ends after 2 beats", int'(wr_owner_valid), 0);
        chk_eq("R6 read still running", int'(rd_owner_valid), 1);
        tick();
        chk_eq("R6 read after 3 beats", int'(rd_owner_valid), 1);
        tick();
        rd_beat = 1'b0;
        chk_eq("R6 read ends after 4 beats", int'(rd_owner_valid), 0);
    endtask

    task automatic t_pipelined();
        do_reset();
        accept_one(0, 1'b0, 2, "R10 first read");
        accept_one(1, 1'b0, 0, "R10 second read");
        chk_eq("R10 first owns", int'(rd_owner), 0);
        pulse_rd();
        chk_eq("R10 waits beat1", int'(rd_owner), 0);
        pulse_rd();
        chk_eq("R10 waits beat2", int'(rd_owner), 0);
        pulse_rd();
        chk_eq("R10 second takes over", int'(rd_owner), 1);
        chk_eq("R10 owner valid", int'(rd_owner_valid), 1);
        pulse_rd();
        chk_eq("R10 all done", int'(rd_owner_valid), 0);
    endtask

    task automatic t_full();
        do_reset();
        accept_one(0, 1'b0, 0, "R8 fill 0");
        accept_one(1, 1'b0, 0, "R8 fill 1");
        set_req(2, 1'b0, 0);
        set_req(3, 1'b1, 0);
        tick();
        chk_eq("R8 full read skipped", int'(gnt), 8);
        addr_ack = 1'b1; req_valid[3] = 1'b0;
        tick();
        addr_ack = 1'b0;
        tick();
        chk_eq("R8 read blocked while full", int'(gnt), 0);
        rd_beat = 1'b1;
        tick();
        rd_beat = 1'b0;
        chk_eq("R8 no grant in pop cycle", int'(gnt), 0);
        tick();
        chk_eq("R8 grant after slot frees", int'(gnt), 4);
        addr_ack = 1'b1; req_valid[2] = 1'b0;
        tick();
        addr_ack = 1'b0;
        chk_eq("R8 owner after pop", int'(rd_owner), 1);
    endtask

    task automatic t_ignore();
        do_reset();
        pulse_rd();
        pulse_wr();
        chk_eq("R9 no owner created", int'(rd_owner_valid || wr_owner_valid), 0);
        accept_one(2, 1'b0, 1, "R9 read");
        pulse_rd();
        chk_eq("R9 stray beat not counted", int'(rd_owner_valid), 1);
        pulse_rd();
        chk_eq("R9 ends on own beats", int'(rd_owner_valid), 0);
    endtask

    initial begin
        rst = 1'b1; req_valid = '0; req_write = '0; req_len = '0;
        addr_ack = 1'b0; rd_beat = 1'b0; wr_beat = 1'b0;
        t_reset();
        t_single();
        t_round_robin();
        t_hold();
        t_concurrent();
        t_pipelined();
        t_full();
        t_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule